// File: doc/BRIEF.md
# Low-Resolution VGA Scan-Out Engine

This block produces the two active-low sync signals for an 800x600-class raster and sends a small frame buffer, one byte per pixel, out of a parallel colour port. A free-running horizontal tick counter defines each scan line. A vertical line counter steps once per line. When the line counter reaches the end of the vertical back porch, a frame window opens. While the window is open, every line start, at the tick where the horizontal back porch ends, launches a burst that reads one stored row from an external frame-buffer read port and presents its bytes at a slow pixel rate.

Each stored row is held on four consecutive scan lines before the next row is fetched. A burst carries HSIZE+3 bytes, and each byte stays on the port for nine clocks. The pacing comes from a divide-by-three prescaler followed by a divide-by-three counter. Both are held at zero between bursts, so every burst has the same phase relative to its line start. After the fourth repetition of the last row, the window closes, the row and repeat counters clear, the next read address returns to the buffer base, and a one-clock frame-done pulse is raised.

The pixel output uses a valid qualifier (`pix_valid`) with no ready signal. The raster cannot stall, so the consumer must take `pix_data` on every clock in which `pix_valid` is high, and back-pressure is not supported. The frame-buffer port is a plain request/data pair with a fixed latency of one clock. `mem_rd_en` and `mem_rd_addr` are issued one clock before the byte is needed, and `mem_rd_data` must be valid on the following clock.

Top module: `vga_scanout`

## Requirements
- R1: While `rst_n` is low, `hsync_n`=0, `vsync_n`=0, `pix_valid`=0, `pix_data`=0, `mem_rd_en`=0 and `frame_done`=0. The first clock after release is tick 1 of line 0.
- R2: A line lasts H_TOTAL ticks (0..H_TOTAL-1), and `hsync_n` is low exactly on ticks 0..H_SYNC-1.
- R3: A frame lasts V_TOTAL lines, and the line counter advances when the tick counter wraps. `vsync_n` is low exactly on lines 0..V_SYNC-1.
- R4: Reads and pixels occur only on lines V_ACT_START through V_ACT_START+4*VSIZE-1 of each frame. On all other lines `mem_rd_en` and `pix_valid` stay 0.
- R5: On a burst line with A = H_ACT_START, the read for byte j (j = 0..HSIZE+2) is issued on tick A+8+9j. Byte j is presented with `pix_valid`=1 on ticks A+10+9j through A+18+9j. `pix_valid` is 0 from tick A+10+9*(HSIZE+3) until the next burst.
- R6: Byte j on burst line V_ACT_START+k reads address (k/4)*(HSIZE+3)+j. It presents the value returned on `mem_rd_data` one clock after that read.
- R7: `pix_data` is 0 on every clock in which `pix_valid` is 0.
- R8: `frame_done` is high for exactly one clock, at tick A+10+9*(HSIZE+3) of the last burst line. The next frame's first read is address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock; one horizontal tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| mem_rd_en | output | 1 | Frame-buffer read request |
| mem_rd_addr | output | ADDR_W | Frame-buffer byte address |
| mem_rd_data | input | PIX_W | Read data, valid one clock after request |
| pix_valid | output | 1 | Colour byte is being presented |
| pix_data | output | PIX_W | Colour byte, zero when not valid |
| frame_done | output | 1 | One-clock pulse when the frame window closes |

## Verification
The assertions check, on every clock, several properties. The horizontal sync never stays low longer than its width. Colour stays zero outside a burst. No pixel appears during vertical sync or outside an open frame window. Each new pixel follows a read issued two clocks before. The frame-done pulse coincides with the window closing and lasts one clock. The exact tick of every read and every byte, the address sequence with its four-fold row repetition, the window position and the restart at the buffer base after each frame and after a mid-frame reset come only from the bench. Its behavioural raster model predicts these values from the cycle count.

// File: rtl/vga_scan_pkg.sv
package vga_scan_pkg;

  // Width needed to hold values 0..n-1, never less than one bit.
  function automatic int bits_for(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Number of scan lines that show one stored row.
  localparam int ROW_REPEAT = 4;

  // Bytes per stored row beyond the visible width.
  localparam int ROW_PAD = 3;

endpackage

// File: rtl/vga_htimer.sv
module vga_htimer
  import vga_scan_pkg::*;
#(
  parameter int H_TOTAL     = 2048,
  parameter int H_SYNC      = 144,
  parameter int H_ACT_START = 364
) (
  input  logic clk,
  input  logic rst_n,
  output logic hsync_n,
  output logic line_begin,
  output logic line_start,
  output logic line_end
);
  localparam int HW = bits_for(H_TOTAL);

  logic [HW-1:0] tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick <= '0;
    end else if (line_end) begin
      tick <= '0;
    end else begin
      tick <= tick + 1'b1;
    end
  end

  assign line_end   = (tick == HW'(H_TOTAL - 1));
  assign line_begin = (tick == '0);
  assign line_start = (tick == HW'(H_ACT_START));
  assign hsync_n    = (tick >= HW'(H_SYNC));

endmodule

// File: rtl/vga_vtimer.sv
module vga_vtimer
  import vga_scan_pkg::*;
#(
  parameter int V_TOTAL     = 625,
  parameter int V_SYNC      = 2,
  parameter int V_ACT_START = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic advance,
  output logic vsync_n,
  output logic at_act_top
);
  localparam int VW = bits_for(V_TOTAL);

  logic [VW-1:0] line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line <= '0;
    end else if (advance) begin
      if (line == VW'(V_TOTAL - 1)) begin
        line <= '0;
      end else begin
        line <= line + 1'b1;
      end
    end
  end

  assign vsync_n    = (line >= VW'(V_SYNC));
  assign at_act_top = (line == VW'(V_ACT_START));

endmodule

// File: rtl/vga_pix_pacer.sv
module vga_pix_pacer
  import vga_scan_pkg::*;
#(
  parameter int PRE_DIV  = 3,
  parameter int POST_DIV = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic fetch_tick,
  output logic strobe
);
  localparam int PW = bits_for(PRE_DIV);
  localparam int QW = bits_for(POST_DIV);

  logic [PW-1:0] pre;
  logic [QW-1:0] post;
  logic          pre_last;
  logic          post_last;

  assign pre_last  = (pre == PW'(PRE_DIV - 1));
  assign post_last = (post == QW'(POST_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre  <= '0;
      post <= '0;
    end else if (!en) begin
      pre  <= '0;
      post <= '0;
    end else if (pre_last) begin
      pre  <= '0;
      post <= post_last ? '0 : post + 1'b1;
    end else begin
      pre  <= pre + 1'b1;
    end
  end

  assign strobe = en && pre_last && post_last;

  // The fetch request leads the strobe by one clock; where that clock
  // falls depends on whether the prescaler divides at all.
  generate
    if (PRE_DIV >= 2) begin : g_pre_lead
      assign fetch_tick = en && (pre == PW'(PRE_DIV - 2)) && post_last;
    end else begin : g_post_lead
      assign fetch_tick = en && (post == QW'(POST_DIV - 2));
    end
  endgenerate

endmodule

// File: rtl/vga_row_fetch.sv
module vga_row_fetch
  import vga_scan_pkg::*;
#(
  parameter int HSIZE  = 160,
  parameter int VSIZE  = 150,
  parameter int PIX_W  = 8,
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_open,
  input  logic              line_start,
  input  logic              fetch_tick,
  input  logic              strobe,
  input  logic [PIX_W-1:0]  rd_data,
  output logic              busy,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              pix_valid,
  output logic [PIX_W-1:0]  pix_data,
  output logic              frame_valid,
  output logic              frame_done
);
  localparam int ROW_BYTES = HSIZE + ROW_PAD;
  localparam int IW        = bits_for(ROW_BYTES + 1);
  localparam int RW        = bits_for(VSIZE);
  localparam int PW        = bits_for(ROW_REPEAT);

  logic [IW-1:0]     idx;
  logic [RW-1:0]     row;
  logic [PW-1:0]     rep;
  logic [ADDR_W-1:0] base;
  logic              last_slot;

  assign last_slot = (idx == IW'(ROW_BYTES));
  assign rd_en     = busy && fetch_tick && !last_slot;
  assign rd_addr   = base + ADDR_W'(idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      idx         <= '0;
      row         <= '0;
      rep         <= '0;
      base        <= '0;
      pix_valid   <= 1'b0;
      pix_data    <= '0;
      frame_valid <= 1'b0;
      frame_done  <= 1'b0;
    end else begin
      frame_done <= 1'b0;

      if (frame_open) begin
        frame_valid <= 1'b1;
      end

      if (line_start && frame_valid && !busy) begin
        busy <= 1'b1;
        idx  <= '0;
      end

      if (busy && strobe) begin
        if (last_slot) begin
          busy      <= 1'b0;
          pix_valid <= 1'b0;
          pix_data  <= '0;
          if (rep == PW'(ROW_REPEAT - 1)) begin
            rep <= '0;
            if (row == RW'(VSIZE - 1)) begin
              row         <= '0;
              base        <= '0;
              frame_valid <= 1'b0;
              frame_done  <= 1'b1;
            end else begin
              row  <= row + 1'b1;
              base <= base + ADDR_W'(ROW_BYTES);
            end
          end else begin
            rep <= rep + 1'b1;
          end
        end else begin
          pix_valid <= 1'b1;
          pix_data  <= rd_data;
          idx       <= idx + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/vga_scanout.sv
module vga_scanout
  import vga_scan_pkg::*;
#(
  parameter int H_TOTAL     = 2048,
  parameter int H_SYNC      = 144,
  parameter int H_ACT_START = 364,
  parameter int V_TOTAL     = 625,
  parameter int V_SYNC      = 2,
  parameter int V_ACT_START = 24,
  parameter int HSIZE       = 160,
  parameter int VSIZE       = 150,
  parameter int PRE_DIV     = 3,
  parameter int POST_DIV    = 3,
  parameter int PIX_W       = 8,
  parameter int ADDR_W      = bits_for((HSIZE + ROW_PAD) * VSIZE)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [PIX_W-1:0]  mem_rd_data,
  output logic              pix_valid,
  output logic [PIX_W-1:0]  pix_data,
  output logic              frame_done
);
  logic line_begin;
  logic line_start;
  logic line_end;
  logic at_act_top;
  logic frame_open;
  logic busy;
  logic fetch_tick;
  logic strobe;
  logic frame_valid;

  vga_htimer #(
    .H_TOTAL    (H_TOTAL),
    .H_SYNC     (H_SYNC),
    .H_ACT_START(H_ACT_START)
  ) u_htimer (
    .clk       (clk),
    .rst_n     (rst_n),
    .hsync_n   (hsync_n),
    .line_begin(line_begin),
    .line_start(line_start),
    .line_end  (line_end)
  );

  vga_vtimer #(
    .V_TOTAL    (V_TOTAL),
    .V_SYNC     (V_SYNC),
    .V_ACT_START(V_ACT_START)
  ) u_vtimer (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance   (line_end),
    .vsync_n   (vsync_n),
    .at_act_top(at_act_top)
  );

  assign frame_open = at_act_top && line_begin;

  vga_pix_pacer #(
    .PRE_DIV (PRE_DIV),
    .POST_DIV(POST_DIV)
  ) u_pacer (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (busy),
    .fetch_tick(fetch_tick),
    .strobe    (strobe)
  );

  vga_row_fetch #(
    .HSIZE (HSIZE),
    .VSIZE (VSIZE),
    .PIX_W (PIX_W),
    .ADDR_W(ADDR_W)
  ) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_open (frame_open),
    .line_start (line_start),
    .fetch_tick (fetch_tick),
    .strobe     (strobe),
    .rd_data    (mem_rd_data),
    .busy       (busy),
    .rd_en      (mem_rd_en),
    .rd_addr    (mem_rd_addr),
    .pix_valid  (pix_valid),
    .pix_data   (pix_data),
    .frame_valid(frame_valid),
    .frame_done (frame_done)
  );

endmodule

// File: rtl/vga_scanout_chk.sv
module vga_scanout_chk #(
  parameter int H_SYNC = 144,
  parameter int PIX_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hsync_n,
  input logic             vsync_n,
  input logic             mem_rd_en,
  input logic             pix_valid,
  input logic [PIX_W-1:0] pix_data,
  input logic             frame_done,
  input logic             frame_valid
);
  logic [15:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run <= '0;
    end else if (!hsync_n) begin
      low_run <= low_run + 1'b1;
    end else begin
      low_run <= '0;
    end
  end

  // R2
  hsync_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hsync_n |-> (low_run < 16'(H_SYNC)));

  // R7
  blank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> (pix_data == '0));

  // R4
  vsync_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_n |-> !pix_valid);

  // R4
  window_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_valid) |-> frame_valid);

  // R6
  read_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_valid) |-> $past(mem_rd_en, 2));

  // R8
  done_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $fell(frame_valid));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

endmodule

bind vga_scanout vga_scanout_chk #(
  .H_SYNC(H_SYNC),
  .PIX_W (PIX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hsync_n    (hsync_n),
  .vsync_n    (vsync_n),
  .mem_rd_en  (mem_rd_en),
  .pix_valid  (pix_valid),
  .pix_data   (pix_data),
  .frame_done (frame_done),
  .frame_valid(frame_valid)
);

// File: tb/vga_scanout_tb.sv
`timescale 1ns/1ps
module vga_scanout_tb;
  localparam int HT    = 96;
  localparam int HS    = 8;
  localparam int HA    = 16;
  localparam int VT    = 30;
  localparam int VS    = 2;
  localparam int VA    = 5;
  localparam int HSZ   = 3;
  localparam int VSZ   = 4;
  localparam int ROWB  = HSZ + 3;
  localparam int AW    = 5;
  localparam int FRAME = HT * VT;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hsync_n, vsync_n, mem_rd_en, pix_valid, frame_done;
  logic [AW-1:0] mem_rd_addr;
  logic [7:0]    mem_rd_data;
  logic [7:0]    pix_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  vga_scanout #(
    .H_TOTAL(HT), .H_SYNC(HS), .H_ACT_START(HA),
    .V_TOTAL(VT), .V_SYNC(VS), .V_ACT_START(VA),
    .HSIZE(HSZ), .VSIZE(VSZ), .ADDR_W(AW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .pix_valid(pix_valid),
    .pix_data(pix_data), .frame_done(frame_done)
  );

  function automatic logic [7:0] content(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  // Frame buffer model: one clock of read latency.
  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= content(int'(mem_rd_addr));
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Compare every output against the raster model at cycle n after reset.
  task automatic compare(input int n);
    int  h, v, line, row, rel, j;
    bit  inwin, e_rd, e_pv, e_fd;
    int  e_addr, e_data;
    h     = n % HT;
    v     = (n / HT) % VT;
    line  = v - VA;
    inwin = (line >= 0) && (line < 4 * VSZ);
    row   = inwin ? line / 4 : 0;
    rel   = h - HA;
    e_rd  = inwin && rel >= 8 && ((rel - 8) % 9 == 0) && ((rel - 8) / 9 < ROWB);
    e_addr = row * ROWB + (rel - 8) / 9;
    j     = (rel - 10) / 9;
    e_pv  = inwin && rel >= 10 && j < ROWB;
    e_data = e_pv ? int'(content(row * ROWB + j)) : 0;
    e_fd  = (v == VA + 4 * VSZ - 1) && (rel == 10 + 9 * ROWB);
    // R2
    check(hsync_n == (h >= HS), "R2", "hsync_n", hsync_n, h >= HS);
    // R3
    check(vsync_n == (v >= VS), "R3", "vsync_n", vsync_n, v >= VS);
    // R4 outside window, R5 timing inside
    check(mem_rd_en == e_rd, inwin ? "R5" : "R4", "mem_rd_en", mem_rd_en, e_rd);
    check(pix_valid == e_pv, inwin ? "R5" : "R4", "pix_valid", pix_valid, e_pv);
    // R6 and R8 (address restarts at base each frame)
    if (e_rd)
      check(int'(mem_rd_addr) == e_addr, "R6/R8", "mem_rd_addr",
            int'(mem_rd_addr), e_addr);
    // R6 content when valid, R7 zero when blank
    check(int'(pix_data) == e_data, e_pv ? "R6" : "R7", "pix_data",
          int'(pix_data), e_data);
    // R8
    check(frame_done == e_fd, "R8", "frame_done", frame_done, e_fd);
  endtask

  task automatic check_reset();
    // R1
    check(hsync_n == 1'b0,   "R1", "hsync_n in reset",    hsync_n, 0);
    check(vsync_n == 1'b0,   "R1", "vsync_n in reset",    vsync_n, 0);
    check(pix_valid == 1'b0, "R1", "pix_valid in reset",  pix_valid, 0);
    check(pix_data == 8'd0,  "R1", "pix_data in reset",   pix_data, 0);
    check(mem_rd_en == 1'b0, "R1", "mem_rd_en in reset",  mem_rd_en, 0);
    check(frame_done == 1'b0,"R1", "frame_done in reset", frame_done, 0);
  endtask

  task automatic run_cycles(input int count);
    for (int n = 1; n <= count; n++) begin
      @(posedge clk);
      @(negedge clk);
      compare(n);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset();
    rst_n = 1'b1;
    // Three full frames from reset, then part of a fourth.
    run_cycles(3 * FRAME + FRAME / 2);
    // Mid-frame reset: state clears and the raster restarts at line 0.
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check_reset();
    rst_n = 1'b1;
    run_cycles(2 * FRAME);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule